// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into parallel characters. A one-cycle enable at sixteen times the bit rate sets its timing. The line first passes through a two-flop synchroniser. A low level seen on an enable pulse while the receiver is idle begins a candidate start bit. Eight enable pulses later the line is sampled again. If it has gone back high, the event is treated as noise and dropped. Otherwise the data bits, the optional parity bit and the first stop bit are each sampled sixteen enables apart, which places every sample near the centre of its bit.

Each finished character goes into a sixteen-entry receive queue. Every entry holds the data together with three tags: parity error, framing error and break. The data bits arrive least-significant first. A host reads from the head of the queue, which is always visible, and asserts a read strobe to remove it. Two outputs report the queue state. The ready output shows that at least one character is waiting. The interrupt request shows that the fill level has reached a selected threshold. If a character completes while the queue is full, that character is dropped and a one-cycle overrun pulse is raised.

Four static configuration inputs are sampled by the block: word length, parity mode, stop-bit count and threshold.

Top module: `uart_rx_core`

## Requirements
- R1: A low pulse on `rxd` that has ended by the eighth enable pulse after it was detected is rejected. It loads no character, and a proper frame that follows it is received normally.
- R2: Data bits are taken least-significant first. `cfg_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 bits, and the unused upper bits of `rd_data` read as zero.
- R3: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_mode` selects how it is checked: 0 means odd (data plus parity hold an odd number of ones), 1 means even, 2 means the bit must be 1, and 3 means the bit must be 0. A mismatch sets `rd_perr` for that character only. When `cfg_par_en` is 0, no parity bit is expected and `rd_perr` is 0.
- R4: A low level sampled at the first stop bit sets `rd_ferr` for that character. After such a character, the receiver waits for the line to return high before it looks for another start bit.
- R5: When `cfg_stop2` is 1, the second stop bit is timed but never checked. A low level there raises no tag and creates no extra character.
- R6: A frame whose data, parity and stop samples are all low loads exactly one entry, however long the line stays low. That entry has data 0, `rd_brk` set to 1, `rd_ferr` set to 1 and `rd_perr` set to 0. A frame sent after the line returns high is received normally.
- R7: The queue holds 16 characters in arrival order. The head entry is shown on the `rd_*` outputs, and one entry is removed at each clock edge where `rd_en` is high while entries are present.
- R8: A character that completes while the queue holds 16 entries, with no read in that cycle, is discarded. `rx_ovr` is then high for exactly one cycle, and the 16 stored entries are left unchanged.
- R9: `rx_irq` is high exactly when the fill level is at least the threshold chosen by `cfg_trig`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R10: `rx_ready` is high exactly when the queue holds at least one character.
- R11: After reset, `rx_ready`, `rx_irq` and `rx_ovr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length select (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity check mode |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_trig | input | 2 | Interrupt threshold select |
| rd_en | input | 1 | Remove head entry |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error tag |
| rd_ferr | output | 1 | Head entry framing error tag |
| rd_brk | output | 1 | Head entry break tag |
| rx_ready | output | 1 | Queue not empty |
| rx_irq | output | 1 | Fill level at or above threshold |
| rx_ovr | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The hardest case to reach from the ports is the overrun. It needs a seventeenth complete frame to finish while sixteen characters are still unread. The stimulus gets there by stopping the reading process and streaming frames back to back. Along the way it checks the interrupt just below and just at the top threshold. It then counts the overrun pulses and drains the queue to confirm that the first sixteen entries survived in order. The break case is also delicate. The line is held low for thirty bit times to show that only one tagged zero entry appears, followed by a normal frame once the line is high again.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OVS   = 16;
    localparam int OVS_W = $clog2(OVS);

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_STOP2,
        ST_HOLD
    } rx_state_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxs,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop2,
    output logic       char_vld,
    output rx_char_t   char_out
);

    localparam logic [OVS_W-1:0] HALF_LAST = OVS_W'(OVS / 2 - 1);
    localparam logic [OVS_W-1:0] FULL_LAST = OVS_W'(OVS - 1);

    typedef struct packed {
        rx_state_e        st;
        logic [OVS_W-1:0] tcnt;
        logic [2:0]       bidx;
        logic [7:0]       sh;
        logic             par;
        logic             vld;
        rx_char_t         chr;
    } frame_regs_t;

    frame_regs_t r_d, r_q;

    logic [2:0] last_idx;
    logic       bit_end;
    logic       par_x;
    logic       perr_calc;
    logic       all_low;

    always_comb begin
        last_idx = 3'd4 + {1'b0, cfg_wlen};
        bit_end  = tick && (r_q.tcnt == FULL_LAST);
        par_x    = (^r_q.sh) ^ r_q.par;

        perr_calc = 1'b0;
        if (cfg_par_en) begin
            case (par_mode_e'(cfg_par_mode))
                PAR_ODD:   perr_calc = !par_x;
                PAR_EVEN:  perr_calc = par_x;
                PAR_MARK:  perr_calc = !r_q.par;
                default:   perr_calc = r_q.par;
            endcase
        end

        all_low = (r_q.sh == 8'd0) && !rxs && !(cfg_par_en && r_q.par);

        r_d     = r_q;
        r_d.vld = 1'b0;

        case (r_q.st)
            ST_IDLE: begin
                if (tick && !rxs) begin
                    r_d.st   = ST_START;
                    r_d.tcnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (r_q.tcnt == HALF_LAST) begin
                        r_d.tcnt = '0;
                        if (!rxs) begin
                            r_d.st   = ST_DATA;
                            r_d.bidx = '0;
                            r_d.sh   = '0;
                            r_d.par  = 1'b0;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_end) begin
                    r_d.tcnt         = '0;
                    r_d.sh[r_q.bidx] = rxs;
                    if (r_q.bidx == last_idx) begin
                        r_d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    end else begin
                        r_d.bidx = r_q.bidx + 1'b1;
                    end
                end else if (tick) begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            ST_PAR: begin
                if (bit_end) begin
                    r_d.tcnt = '0;
                    r_d.par  = rxs;
                    r_d.st   = ST_STOP;
                end else if (tick) begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    r_d.tcnt      = '0;
                    r_d.vld       = 1'b1;
                    r_d.chr.data  = r_q.sh;
                    r_d.chr.ferr  = !rxs;
                    r_d.chr.brk   = all_low;
                    r_d.chr.perr  = all_low ? 1'b0 : perr_calc;
                    if (!rxs)           r_d.st = ST_HOLD;
                    else if (cfg_stop2) r_d.st = ST_STOP2;
                    else                r_d.st = ST_IDLE;
                end else if (tick) begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            ST_STOP2: begin
                if (bit_end) begin
                    r_d.tcnt = '0;
                    r_d.st   = ST_IDLE;
                end else if (tick) begin
                    r_d.tcnt = r_q.tcnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (tick && rxs) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign char_vld = r_q.vld;
    assign char_out = r_q.chr;

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_char_t      din,
    input  logic          pop_req,
    output rx_char_t      head,
    output logic [CW-1:0] fill,
    output logic          ovr
);

    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [AW-1:0]        wp;
        logic [AW-1:0]        rp;
        logic [CW-1:0]        cnt;
        logic                 ovr;
    } fifo_regs_t;

    fifo_regs_t r_d, r_q;

    logic do_pop;
    logic do_push;

    always_comb begin
        do_pop  = pop_req && (r_q.cnt != '0);
        do_push = push && ((r_q.cnt != CNT_FULL) || do_pop);

        r_d     = r_q;
        r_d.ovr = push && !do_push;

        if (do_push) begin
            r_d.mem[r_q.wp] = din;
            r_d.wp          = (r_q.wp == PTR_LAST) ? '0 : r_q.wp + 1'b1;
        end
        if (do_pop) begin
            r_d.rp = (r_q.rp == PTR_LAST) ? '0 : r_q.rp + 1'b1;
        end

        case ({do_push, do_pop})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign head = r_q.mem[r_q.rp];
    assign fill = r_q.cnt;
    assign ovr  = r_q.ovr;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_wlen,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_stop2,
    input  logic [1:0] cfg_trig,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       rx_ready,
    output logic       rx_irq,
    output logic       rx_ovr
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          rxs;
    logic          char_vld;
    rx_char_t      char_q;
    rx_char_t      head;
    logic [CW-1:0] fill_cnt;
    logic [31:0]   fill_w;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxs)
    );

    uart_rx_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .rxs         (rxs),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_mode(cfg_par_mode),
        .cfg_stop2   (cfg_stop2),
        .char_vld    (char_vld),
        .char_out    (char_q)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (char_vld),
        .din    (char_q),
        .pop_req(rd_en),
        .head   (head),
        .fill   (fill_cnt),
        .ovr    (rx_ovr)
    );

    always_comb begin
        fill_w   = 32'(fill_cnt);
        rx_ready = (fill_cnt != '0);
        rx_irq   = (fill_w >= trig_level(cfg_trig));
        rd_data  = head.data;
        rd_perr  = head.perr;
        rd_ferr  = head.ferr;
        rd_brk   = head.brk;
    end

endmodule

// File: rtl/uart_rx_chk.sv
module uart_rx_chk
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          rx_ready,
    input logic          rx_irq,
    input logic          rx_ovr,
    input logic          char_vld,
    input rx_char_t      char_in,
    input logic [CW-1:0] fill
);

    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_ready); // R9

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R7

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == $past(fill)) || (fill == $past(fill) + CW'(1)) || (fill + CW'(1) == $past(fill))); // R7

    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_en) |=> $stable(rd_data)); // R7

    AST_OVR_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> ($past(fill) == CW'(DEPTH))); // R8

    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |=> !rx_ovr); // R8

    AST_BRK_ZERO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && char_in.brk) |-> (char_in.data == 8'd0 && char_in.ferr && !char_in.perr)); // R6

    AST_CHAR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld |=> !char_vld); // R2

endmodule

bind uart_rx_core uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rx_ready(rx_ready),
    .rx_irq  (rx_irq),
    .rx_ovr  (rx_ovr),
    .char_vld(char_vld),
    .char_in (char_q),
    .fill    (fill_cnt)
);

// File: tb/sim_uart_rx_core.sv
`timescale 1ns/1ps
module sim_uart_rx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b1;
    logic [1:0] cfg_par_mode = 2'd1;
    logic       cfg_stop2 = 1'b0;
    logic [1:0] cfg_trig = 2'd0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk, rx_ready, rx_irq, rx_ovr;

    typedef struct packed {
        logic [7:0] d;
        logic       p;
        logic       f;
        logic       b;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    ovr_seen = 0;
    bit    drain = 1'b0;
    int    tdiv = 0;

    always #2 clk = ~clk;

    uart_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .cfg_stop2(cfg_stop2), .cfg_trig(cfg_trig), .rd_en(rd_en),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rx_ready(rx_ready), .rx_irq(rx_irq), .rx_ovr(rx_ovr)
    );

    always @(negedge clk) begin
        tdiv   <= (tdiv == 3) ? 0 : tdiv + 1;
        tick16 <= (tdiv == 3);
        if (rx_ovr) ovr_seen <= ovr_seen + 1;
    end

    task automatic check_val(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected entries as characters appear at the head
    initial begin
        forever begin
            @(negedge clk);
            if (drain && rx_ready) begin
                exp_t  e;
                string t;
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R7 unexpected char actual=%h expected=none", rd_data);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if ({rd_data, rd_perr, rd_ferr, rd_brk} != e) begin
                        n_bad++;
                        $display("FAIL %s actual=%h p%0d f%0d b%0d expected=%h p%0d f%0d b%0d",
                                 t, rd_data, rd_perr, rd_ferr, rd_brk, e.d, e.p, e.f, e.b);
                    end
                end
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
    end

    task automatic line_bit(input logic v);
        @(negedge clk);
        rxd = v;
        repeat (63) @(negedge clk);
    endtask

    // Driver: queue the expected entry, then put the frame on the line
    task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                              input bit stop2_low, input bit exp_it, input string tag);
        logic [7:0] mask;
        logic [7:0] dm;
        logic       pb;
        int         nb;
        mask = 8'hFF >> (3 - cfg_wlen);
        dm   = d & mask;
        nb   = 5 + int'(cfg_wlen);
        case (cfg_par_mode)
            2'd0:    pb = ~^dm;
            2'd1:    pb = ^dm;
            2'd2:    pb = 1'b1;
            default: pb = 1'b0;
        endcase
        if (exp_it) begin
            exp_q.push_back({dm, bad_par && cfg_par_en, bad_stop, 1'b0});
            tag_q.push_back(tag);
        end
        line_bit(1'b0);
        for (int i = 0; i < nb; i++) line_bit(dm[i]);
        if (cfg_par_en) line_bit(pb ^ bad_par);
        line_bit(!bad_stop);
        if (cfg_stop2) line_bit(!stop2_low);
        if (bad_stop || stop2_low) line_bit(1'b1);
    endtask

    task automatic wait_drain(input string req);
        for (int i = 0; i < 4000 && (exp_q.size() != 0 || rx_ready); i++) @(negedge clk);
        repeat (4) @(negedge clk);
        check_val(req, exp_q.size(), 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        check_val("R11 ready", int'(rx_ready), 0);
        check_val("R11 irq", int'(rx_irq), 0);
        check_val("R11 ovr", int'(rx_ovr), 0);
        drain = 1'b1;

        // R2 eight-bit words, even parity
        send_frame(8'hA5, 0, 0, 0, 1, "R2 8bit A5");
        send_frame(8'h3C, 0, 0, 0, 1, "R2 8bit 3C");
        send_frame(8'h01, 0, 0, 0, 1, "R2 8bit 01");
        // R2 shorter words
        cfg_wlen = 2'd0; send_frame(8'hFF, 0, 0, 0, 1, "R2 5bit");
        cfg_wlen = 2'd1; send_frame(8'hEA, 0, 0, 0, 1, "R2 6bit");
        cfg_wlen = 2'd2; send_frame(8'hD3, 0, 0, 0, 1, "R2 7bit");
        cfg_wlen = 2'd3;
        wait_drain("R2 all words received");

        // R3 parity modes
        cfg_par_mode = 2'd0; send_frame(8'h5A, 0, 0, 0, 1, "R3 odd ok");
        send_frame(8'h5B, 1, 0, 0, 1, "R3 odd bad");
        cfg_par_mode = 2'd1; send_frame(8'h81, 1, 0, 0, 1, "R3 even bad");
        cfg_par_mode = 2'd2; send_frame(8'h12, 0, 0, 0, 1, "R3 mark ok");
        send_frame(8'h13, 1, 0, 0, 1, "R3 mark bad");
        cfg_par_mode = 2'd3; send_frame(8'h24, 0, 0, 0, 1, "R3 space ok");
        send_frame(8'h25, 1, 0, 0, 1, "R3 space bad");
        cfg_par_en = 1'b0; send_frame(8'hC7, 0, 0, 0, 1, "R3 no parity");
        cfg_par_en = 1'b1; cfg_par_mode = 2'd1;
        send_frame(8'h66, 0, 0, 0, 1, "R3 tag cleared next char");
        wait_drain("R3 all parity chars received");

        // R4 framing error then normal frame
        send_frame(8'h55, 0, 1, 0, 1, "R4 framing tag");
        send_frame(8'hAA, 0, 0, 0, 1, "R4 recovery");
        wait_drain("R4 chars received");

        // R1 false start: low for four enable periods
        @(negedge clk); rxd = 1'b0;
        repeat (16) @(negedge clk); rxd = 1'b1;
        repeat (128) @(negedge clk);
        check_val("R1 no char after glitch", int'(rx_ready), 0);
        send_frame(8'h3E, 0, 0, 0, 1, "R1 frame after glitch");
        wait_drain("R1 frame received");

        // R5 second stop bit unchecked
        cfg_stop2 = 1'b1;
        send_frame(8'h96, 0, 0, 1, 1, "R5 low second stop");
        send_frame(8'h69, 0, 0, 0, 1, "R5 two stop bits");
        wait_drain("R5 no extra char");
        cfg_stop2 = 1'b0;

        // R6 long break
        exp_q.push_back({8'h00, 1'b0, 1'b1, 1'b1});
        tag_q.push_back("R6 break entry");
        @(negedge clk); rxd = 1'b0;
        repeat (30 * 64) @(negedge clk);
        rxd = 1'b1;
        repeat (128) @(negedge clk);
        send_frame(8'h77, 0, 0, 0, 1, "R6 frame after break");
        wait_drain("R6 single break entry");

        // R9 / R10 thresholds
        drain = 1'b0;
        cfg_trig = 2'd1;
        for (int i = 0; i < 3; i++) send_frame(8'(8'h40 + i), 0, 0, 0, 1, "R7 order trig4");
        check_val("R10 ready with 3", int'(rx_ready), 1);
        check_val("R9 irq below 4", int'(rx_irq), 0);
        send_frame(8'h43, 0, 0, 0, 1, "R7 order trig4");
        check_val("R9 irq at 4", int'(rx_irq), 1);
        cfg_trig = 2'd2;
        @(negedge clk);
        check_val("R9 irq below 8", int'(rx_irq), 0);
        cfg_trig = 2'd0;
        @(negedge clk);
        check_val("R9 irq at 1", int'(rx_irq), 1);
        drain = 1'b1;
        wait_drain("R7 trig chars drained");
        check_val("R10 ready empty", int'(rx_ready), 0);
        check_val("R9 irq empty", int'(rx_irq), 0);

        // R8 overrun with top threshold
        drain = 1'b0;
        cfg_trig = 2'd3;
        for (int i = 0; i < 13; i++) send_frame(8'(8'h80 + i), 0, 0, 0, 1, "R8 stored entry");
        check_val("R9 irq below 14", int'(rx_irq), 0);
        send_frame(8'h8D, 0, 0, 0, 1, "R8 stored entry");
        check_val("R9 irq at 14", int'(rx_irq), 1);
        send_frame(8'h8E, 0, 0, 0, 1, "R8 stored entry");
        send_frame(8'h8F, 0, 0, 0, 1, "R8 stored entry");
        check_val("R8 no ovr before full", ovr_seen, 0);
        send_frame(8'hEE, 0, 0, 0, 0, "R8 dropped");
        check_val("R8 one ovr pulse", ovr_seen, 1);
        check_val("R8 head kept", int'(rd_data), 8'h80);
        drain = 1'b1;
        wait_drain("R8 sixteen entries intact");
        cfg_trig = 2'd0;

        finish_run();
    end

endmodule